// File: doc/BRIEF.md
# Inter-core local memory switch

This block lets each of N cores reach the local 32-bit memory of any other core through the spare access port of that memory. Each core acts as a requester. It presents a target core number, a word address, write data and a direction flag, and it receives a grant, an error strobe, and, for reads, returned data with a one-cycle valid strobe. On the target side the switch drives each memory's spare port (enable, write enable, address, write data) and collects the synchronous read data that comes back. The memory arrays and the core pipelines sit outside the block.

A target memory is shared with its owner core. While the owner runs, the spare port is free only in the cycles where the block's free-running slot phase bit is 1. When the owner is stopped, the port is free in every cycle. If several requesters want the same target, the lowest source number wins, and the others keep their requests up and try again in the next open slot. Only N/2 shared buses exist, so when more pairs qualify than that, buses go to sources in ascending number order. A request aimed at the requester's own memory is refused with an error strobe.

Each requester runs a small two-state controller. In state RQ_READY, a request to a running target whose direction differs from the requester's last granted direction needs a turnaround. In the first open slot it takes the stall transition to RQ_TURNED and gets no grant. RQ_TURNED returns to RQ_READY on the grant transition or when the request is withdrawn. A second register holds the last granted direction (DIR_NONE, DIR_READ, DIR_WRITE) and is updated on every grant.

Top module: `xms_switch`

## Requirements
- R1: Disjoint requester/target pairs are served in the same cycle over 32-bit paths. A granted write drives the target's enable and write enable high, with the requester's address and data, in the grant cycle.
- R2: A granted read raises that requester's valid strobe for exactly one cycle, in the cycle after the grant, with the target memory's word at the requested address.
- R3: Among eligible requesters aimed at one target, the lowest source number is granted. A loser that holds its request is granted in a later open slot.
- R4: The slot phase output is 0 in the first cycle after reset and toggles every cycle. A running target, whose core_running bit is 1, is accessed only in cycles with phase 1.
- R5: A stopped target, whose core_running bit is 0, can be accessed in every cycle, whatever the phase.
- R6: At most N/2 grants occur per cycle. When more requesters are eligible, the lowest-numbered ones get the buses and the rest wait.
- R7: If the target is running and the request direction differs from the requester's last granted direction, the first open slot is spent as a stall with no grant, and the grant comes in the next open slot. No stall happens for a stopped target, or when the requester has no previous grant.
- R8: A request whose target equals its own source number gets an error strobe in the same cycle, no grant, and no memory access.
- R9: After reset, no grant and no read valid are asserted, and every requester's last direction is DIR_NONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_running | input | N_CORES | Per core: 1 = owner core running, 0 = stopped |
| req_valid | input | N_CORES | Per requester: request present |
| req_write | input | N_CORES | Per requester: 1 = write, 0 = read |
| req_target | input | N_CORES*TID_W | Per requester: target core number |
| req_addr | input | N_CORES*ADDR_W | Per requester: word address |
| req_wdata | input | N_CORES*DATA_W | Per requester: write data |
| req_grant | output | N_CORES | Per requester: access granted this cycle |
| req_error | output | N_CORES | Per requester: self-targeted request refused |
| req_rvalid | output | N_CORES | Per requester: read data valid |
| req_rdata | output | N_CORES*DATA_W | Per requester: returned read data |
| mem_en | output | N_CORES | Per target memory: spare port enable |
| mem_we | output | N_CORES | Per target memory: spare port write enable |
| mem_addr | output | N_CORES*ADDR_W | Per target memory: spare port address |
| mem_wdata | output | N_CORES*DATA_W | Per target memory: spare port write data |
| mem_rdata | input | N_CORES*DATA_W | Per target memory: synchronous read data, valid one cycle after enable |
| slot_phase | output | 1 | Free-running phase bit; running targets open when 1 |

## Verification
Directed patterns come first. All eight cores request distinct stopped targets, which separates bus limiting from per-target priority. Three sources read one target, which exposes the winner choice and the retry of a held loss. A self-aimed request is tried, and a read after a write is sent to a running target, which tells the turnaround stall apart from the ordinary phase gap. Long random traffic follows, with held and dropped requests and a changing running mask. Every cycle, grants, errors, memory port signals and returned data are compared against a cycle model in the bench that keeps its own memory contents, phase, direction history and turnaround flags.

// File: rtl/xms_pkg.sv
package xms_pkg;
    typedef enum logic [1:0] {
        DIR_NONE  = 2'd0,
        DIR_READ  = 2'd1,
        DIR_WRITE = 2'd2
    } dir_e;

    typedef enum logic {
        RQ_READY  = 1'b0,
        RQ_TURNED = 1'b1
    } rq_state_e;
endpackage

// File: rtl/xms_req_ctrl.sv
module xms_req_ctrl
    import xms_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic write,
    input  logic self_hit,
    input  logic tgt_running,
    input  logic phase,
    input  logic granted,
    output logic turn_block
);
    rq_state_e state_q, state_d;
    dir_e      dir_q, dir_d;
    logic      mismatch;
    logic      stall_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RQ_READY;
            dir_q   <= DIR_NONE;
        end else begin
            state_q <= state_d;
            dir_q   <= dir_d;
        end
    end

    always_comb begin
        mismatch  = (dir_q == DIR_READ && write) || (dir_q == DIR_WRITE && !write);
        stall_now = valid && !self_hit && tgt_running && phase &&
                    (state_q == RQ_READY) && mismatch;
        state_d = state_q;
        unique case (state_q)
            RQ_READY:  if (stall_now) state_d = RQ_TURNED;
            RQ_TURNED: if (granted || !valid) state_d = RQ_READY;
            default:   state_d = RQ_READY;
        endcase
        dir_d = dir_q;
        if (granted) dir_d = write ? DIR_WRITE : DIR_READ;
    end

    always_comb begin
        turn_block = (state_q == RQ_READY) && mismatch && tgt_running;
    end

    // R7: the arbiter never grants a requester that still owes a turnaround
    p_no_grant_blocked_r7: assert property (@(posedge clk) disable iff (rst)
        granted |-> !turn_block);
    // R7: a stall cycle is never spent against a stopped target
    p_turned_from_running_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == RQ_READY && valid && !self_hit && phase && mismatch && !tgt_running)
        |=> state_q == RQ_READY);
endmodule

// File: rtl/xms_arbiter.sv
module xms_arbiter #(
    parameter int N_CORES = 8,
    parameter int TID_W   = 3,
    parameter int BUSES   = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_CORES-1:0]       eligible,
    input  logic [N_CORES*TID_W-1:0] tgt_flat,
    output logic [N_CORES-1:0]       grant
);
    logic [N_CORES-1:0] win;

    // per-target fixed priority: lowest source number wins
    always_comb begin
        win = eligible;
        for (int s = 1; s < N_CORES; s++) begin
            for (int j = 0; j < s; j++) begin
                if (eligible[j] && tgt_flat[j*TID_W +: TID_W] == tgt_flat[s*TID_W +: TID_W])
                    win[s] = 1'b0;
            end
        end
    end

    // shared bus allocation in ascending source order
    always_comb begin
        int used;
        used  = 0;
        grant = '0;
        for (int s = 0; s < N_CORES; s++) begin
            if (win[s] && used < BUSES) begin
                grant[s] = 1'b1;
                used     = used + 1;
            end
        end
    end

    p_bus_limit_r6: assert property (@(posedge clk) disable iff (rst)
        $countones(grant) <= BUSES);
    p_grant_eligible_r3: assert property (@(posedge clk) disable iff (rst)
        (grant & ~eligible) == '0);

    for (genvar t = 0; t < N_CORES; t++) begin : g_tgt_chk
        logic [N_CORES-1:0] hit;
        always_comb begin
            for (int s = 0; s < N_CORES; s++)
                hit[s] = grant[s] && tgt_flat[s*TID_W +: TID_W] == TID_W'(t);
        end
        // R3: one winner per target
        p_one_winner_r3: assert property (@(posedge clk) disable iff (rst)
            $onehot0(hit));
    end
endmodule

// File: rtl/xms_route.sv
module xms_route #(
    parameter int N_CORES = 8,
    parameter int TID_W   = 3,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_CORES-1:0]        grant,
    input  logic [N_CORES-1:0]        write,
    input  logic [N_CORES*TID_W-1:0]  tgt_flat,
    input  logic [N_CORES*ADDR_W-1:0] addr_flat,
    input  logic [N_CORES*DATA_W-1:0] wdata_flat,
    output logic [N_CORES-1:0]        mem_en,
    output logic [N_CORES-1:0]        mem_we,
    output logic [N_CORES*ADDR_W-1:0] mem_addr,
    output logic [N_CORES*DATA_W-1:0] mem_wdata,
    input  logic [N_CORES*DATA_W-1:0] mem_rdata,
    output logic [N_CORES-1:0]        rvalid,
    output logic [N_CORES*DATA_W-1:0] rdata
);
    // forward path: each target port takes the granted source
    for (genvar t = 0; t < N_CORES; t++) begin : g_fwd
        always_comb begin
            mem_en[t]                        = 1'b0;
            mem_we[t]                        = 1'b0;
            mem_addr[t*ADDR_W +: ADDR_W]     = '0;
            mem_wdata[t*DATA_W +: DATA_W]    = '0;
            for (int s = 0; s < N_CORES; s++) begin
                if (grant[s] && tgt_flat[s*TID_W +: TID_W] == TID_W'(t)) begin
                    mem_en[t]                     = 1'b1;
                    mem_we[t]                     = write[s];
                    mem_addr[t*ADDR_W +: ADDR_W]  = addr_flat[s*ADDR_W +: ADDR_W];
                    mem_wdata[t*DATA_W +: DATA_W] = wdata_flat[s*DATA_W +: DATA_W];
                end
            end
        end
    end

    // return path: read data arrives one cycle after the grant
    for (genvar s = 0; s < N_CORES; s++) begin : g_ret
        logic             rv_q;
        logic [TID_W-1:0] rtgt_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                rv_q   <= 1'b0;
                rtgt_q <= '0;
            end else begin
                rv_q   <= grant[s] && !write[s];
                rtgt_q <= tgt_flat[s*TID_W +: TID_W];
            end
        end
        assign rvalid[s]                 = rv_q;
        assign rdata[s*DATA_W +: DATA_W] = mem_rdata[rtgt_q*DATA_W +: DATA_W];

        p_read_return_r2: assert property (@(posedge clk) disable iff (rst)
            rvalid[s] |-> $past(grant[s] && !write[s]));
        p_write_no_return_r2: assert property (@(posedge clk) disable iff (rst)
            (grant[s] && write[s]) |=> !rvalid[s]);
    end
endmodule

// File: rtl/xms_switch.sv
module xms_switch
    import xms_pkg::*;
#(
    parameter int  N_CORES = 8,
    parameter int  ADDR_W  = 8,
    parameter int  DATA_W  = 32,
    localparam int TID_W   = $clog2(N_CORES),
    localparam int BUSES   = N_CORES / 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_CORES-1:0]        core_running,
    input  logic [N_CORES-1:0]        req_valid,
    input  logic [N_CORES-1:0]        req_write,
    input  logic [N_CORES*TID_W-1:0]  req_target,
    input  logic [N_CORES*ADDR_W-1:0] req_addr,
    input  logic [N_CORES*DATA_W-1:0] req_wdata,
    output logic [N_CORES-1:0]        req_grant,
    output logic [N_CORES-1:0]        req_error,
    output logic [N_CORES-1:0]        req_rvalid,
    output logic [N_CORES*DATA_W-1:0] req_rdata,
    output logic [N_CORES-1:0]        mem_en,
    output logic [N_CORES-1:0]        mem_we,
    output logic [N_CORES*ADDR_W-1:0] mem_addr,
    output logic [N_CORES*DATA_W-1:0] mem_wdata,
    input  logic [N_CORES*DATA_W-1:0] mem_rdata,
    output logic                      slot_phase
);
    logic               phase_q;
    logic [N_CORES-1:0] self_hit;
    logic [N_CORES-1:0] tgt_running;
    logic [N_CORES-1:0] turn_block;
    logic [N_CORES-1:0] eligible;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= 1'b0;
        else     phase_q <= ~phase_q;
    end
    assign slot_phase = phase_q;

    for (genvar s = 0; s < N_CORES; s++) begin : g_src
        logic [TID_W-1:0] tgt;
        assign tgt            = req_target[s*TID_W +: TID_W];
        assign self_hit[s]    = (tgt == TID_W'(s));
        assign tgt_running[s] = core_running[tgt];
        assign eligible[s]    = req_valid[s] && !self_hit[s] &&
                                (!tgt_running[s] || phase_q) && !turn_block[s];
        assign req_error[s]   = req_valid[s] && self_hit[s];

        xms_req_ctrl u_ctrl (
            .clk         (clk),
            .rst         (rst),
            .valid       (req_valid[s]),
            .write       (req_write[s]),
            .self_hit    (self_hit[s]),
            .tgt_running (tgt_running[s]),
            .phase       (phase_q),
            .granted     (req_grant[s]),
            .turn_block  (turn_block[s])
        );
    end

    xms_arbiter #(
        .N_CORES (N_CORES),
        .TID_W   (TID_W),
        .BUSES   (BUSES)
    ) u_arb (
        .clk      (clk),
        .rst      (rst),
        .eligible (eligible),
        .tgt_flat (req_target),
        .grant    (req_grant)
    );

    xms_route #(
        .N_CORES (N_CORES),
        .TID_W   (TID_W),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_route (
        .clk        (clk),
        .rst        (rst),
        .grant      (req_grant),
        .write      (req_write),
        .tgt_flat   (req_target),
        .addr_flat  (req_addr),
        .wdata_flat (req_wdata),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .rvalid     (req_rvalid),
        .rdata      (req_rdata)
    );

    p_self_no_grant_r8: assert property (@(posedge clk) disable iff (rst)
        (req_error & req_grant) == '0);

    for (genvar t = 0; t < N_CORES; t++) begin : g_slot_chk
        // R4: running memory touched only in the open phase
        p_running_slot_r4: assert property (@(posedge clk) disable iff (rst)
            (mem_en[t] && core_running[t]) |-> slot_phase);
    end
endmodule

// File: tb/xms_switch_test.sv
module xms_switch_test;
    localparam int N = 8;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int TW = 3;
    localparam int BUSES = N / 2;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] core_running = '0;
    logic [N-1:0] req_valid = '0;
    logic [N-1:0] req_write = '0;
    logic [N*TW-1:0] req_target = '0;
    logic [N*AW-1:0] req_addr = '0;
    logic [N*DW-1:0] req_wdata = '0;
    logic [N-1:0] req_grant, req_error, req_rvalid;
    logic [N*DW-1:0] req_rdata;
    logic [N-1:0] mem_en, mem_we;
    logic [N*AW-1:0] mem_addr;
    logic [N*DW-1:0] mem_wdata;
    logic [N*DW-1:0] mem_rdata = '0;
    logic slot_phase;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    xms_switch uut (
        .clk(clk), .rst(rst), .core_running(core_running),
        .req_valid(req_valid), .req_write(req_write), .req_target(req_target),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_grant(req_grant),
        .req_error(req_error), .req_rvalid(req_rvalid), .req_rdata(req_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .slot_phase(slot_phase)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] seed_word(int t, int a);
        return (32'h1000_0000 * (t + 1)) ^ (32'(a) * 32'h0000_9E37);
    endfunction

    // memories outside the block, synchronous read
    logic [31:0] mem_arr [N][1<<AW];
    always @(posedge clk) begin
        for (int t = 0; t < N; t++) begin
            if (mem_en[t]) begin
                if (mem_we[t]) mem_arr[t][mem_addr[t*AW +: AW]] <= mem_wdata[t*DW +: DW];
                else mem_rdata[t*DW +: DW] <= mem_arr[t][mem_addr[t*AW +: AW]];
            end
        end
    end

    // bench cycle model
    logic [31:0] sh [N][1<<AW];
    bit m_ph;
    int m_dir [N];
    bit m_turn [N];
    bit m_rv [N];
    logic [31:0] m_rd [N];
    bit e_grant [N];
    bit e_stall [N];

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic set_req(int s, bit v, int tg, bit wr, int a, logic [31:0] d);
        req_valid[s] = v;
        req_target[s*TW +: TW] = TW'(tg);
        req_write[s] = wr;
        req_addr[s*AW +: AW] = AW'(a);
        req_wdata[s*DW +: DW] = d;
    endtask

    task automatic clear_reqs();
        for (int s = 0; s < N; s++) set_req(s, 0, 0, 0, 0, 0);
    endtask

    task automatic cyc_eval();
        bit elig [N];
        bit win [N];
        int used;
        @(negedge clk);
        #1;
        for (int s = 0; s < N; s++) begin
            int tg;
            bit v, wr, self, run, mis, blk;
            tg = int'(req_target[s*TW +: TW]);
            v = req_valid[s];
            wr = req_write[s];
            self = (tg == s);
            run = core_running[tg];
            mis = (m_dir[s] == 1 && wr) || (m_dir[s] == 2 && !wr);
            blk = !m_turn[s] && run && mis;
            elig[s] = v && !self && (!run || m_ph) && !blk;
            e_stall[s] = v && !self && run && m_ph && blk;
            chk($sformatf("R8 error src %0d", s), 64'(req_error[s]), 64'(v && self));
        end
        for (int s = 0; s < N; s++) begin
            win[s] = elig[s];
            for (int j = 0; j < s; j++)
                if (elig[j] && req_target[j*TW +: TW] == req_target[s*TW +: TW]) win[s] = 0;
        end
        used = 0;
        for (int s = 0; s < N; s++) begin
            e_grant[s] = win[s] && used < BUSES;
            if (e_grant[s]) used++;
        end
        chk("R4 slot phase", 64'(slot_phase), 64'(m_ph));
        for (int s = 0; s < N; s++) begin
            chk($sformatf("R1/R3/R4/R5/R6/R7 grant src %0d", s), 64'(req_grant[s]), 64'(e_grant[s]));
            chk($sformatf("R2 rvalid src %0d", s), 64'(req_rvalid[s]), 64'(m_rv[s]));
            if (m_rv[s]) chk($sformatf("R2 rdata src %0d", s), 64'(req_rdata[s*DW +: DW]), 64'(m_rd[s]));
        end
        for (int t = 0; t < N; t++) begin
            bit en;
            int src;
            en = 0;
            src = 0;
            for (int s = 0; s < N; s++)
                if (e_grant[s] && int'(req_target[s*TW +: TW]) == t) begin en = 1; src = s; end
            chk($sformatf("R1 mem_en tgt %0d", t), 64'(mem_en[t]), 64'(en));
            if (en && mem_en[t]) begin
                chk("R1 mem_we", 64'(mem_we[t]), 64'(req_write[src]));
                chk("R1 mem_addr", 64'(mem_addr[t*AW +: AW]), 64'(req_addr[src*AW +: AW]));
                if (req_write[src])
                    chk("R1 mem_wdata", 64'(mem_wdata[t*DW +: DW]), 64'(req_wdata[src*DW +: DW]));
            end
        end
    endtask

    task automatic cyc_commit();
        @(posedge clk);
        #1;
        for (int s = 0; s < N; s++) begin
            int tg, a;
            tg = int'(req_target[s*TW +: TW]);
            a = int'(req_addr[s*AW +: AW]);
            m_rv[s] = e_grant[s] && !req_write[s];
            if (m_rv[s]) m_rd[s] = sh[tg][a];
        end
        for (int s = 0; s < N; s++) begin
            int tg, a;
            tg = int'(req_target[s*TW +: TW]);
            a = int'(req_addr[s*AW +: AW]);
            if (e_grant[s]) begin
                m_dir[s] = req_write[s] ? 2 : 1;
                if (req_write[s]) sh[tg][a] = req_wdata[s*DW +: DW];
            end
            if (!m_turn[s]) m_turn[s] = e_stall[s];
            else m_turn[s] = req_valid[s] && !e_grant[s];
        end
        m_ph = !m_ph;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int t = 0; t < N; t++)
            for (int a = 0; a < (1<<AW); a++) begin
                mem_arr[t][a] = seed_word(t, a);
                sh[t][a] = seed_word(t, a);
            end
        for (int s = 0; s < N; s++) begin
            m_dir[s] = 0; m_turn[s] = 0; m_rv[s] = 0; m_rd[s] = '0; e_grant[s] = 0; e_stall[s] = 0;
        end
        m_ph = 0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R9: reset state
        cyc_eval();
        chk("R9 no grant after reset", 64'(req_grant), 64'(0));
        chk("R9 no rvalid after reset", 64'(req_rvalid), 64'(0));
        chk("R9 phase 0 after reset", 64'(slot_phase), 64'(0));
        cyc_commit();

        // R6: eight disjoint writes to stopped targets, only four buses
        core_running = '0;
        for (int s = 0; s < N; s++) set_req(s, 1, (s + 1) % N, 1, s, 32'hA000 + 32'(s));
        cyc_eval();
        chk("R6 lowest four sources get buses", 64'(req_grant), 64'h0F);
        chk("R1 four disjoint targets enabled", 64'(mem_en), 64'h1E);
        cyc_commit();
        for (int s = 0; s < 4; s++) req_valid[s] = 0;
        cyc_eval();
        chk("R6 waiting sources served next, R5 stopped in phase 0", 64'(req_grant), 64'hF0);
        chk("R1 second group targets enabled", 64'(mem_en), 64'hE1);
        cyc_commit();
        clear_reqs();

        // R3: three readers on one stopped target
        set_req(1, 1, 2, 0, 5, 0);
        set_req(4, 1, 2, 0, 5, 0);
        set_req(6, 1, 2, 0, 5, 0);
        cyc_eval();
        chk("R3 lowest source wins", 64'(req_grant), 64'h02);
        cyc_commit();
        req_valid[1] = 0;
        cyc_eval();
        chk("R3 held loser retried", 64'(req_grant), 64'h10);
        cyc_commit();
        clear_reqs();
        cyc_eval();
        chk("R2 read valid for retried reader", 64'(req_rvalid[4]), 64'(1));
        chk("R2 read data for retried reader", 64'(req_rdata[4*DW +: DW]), 64'(seed_word(2, 5)));
        cyc_commit();

        // R8: self-targeted request
        set_req(5, 1, 5, 1, 9, 32'hDEAD);
        cyc_eval();
        chk("R8 error strobe", 64'(req_error), 64'h20);
        chk("R8 no grant", 64'(req_grant), 64'(0));
        chk("R8 no memory access", 64'(mem_en), 64'(0));
        cyc_commit();
        clear_reqs();

        // R7: source 0 last wrote; now reads a running target
        core_running = 8'h80;
        set_req(0, 1, 7, 0, 3, 0);
        cyc_eval();
        chk("R7 turnaround stall in open slot", 64'(req_grant[0]), 64'(0));
        chk("R4 open phase during stall", 64'(slot_phase), 64'(1));
        cyc_commit();
        cyc_eval();
        chk("R4 closed phase no grant", 64'(req_grant[0]), 64'(0));
        cyc_commit();
        cyc_eval();
        chk("R7 grant in next open slot", 64'(req_grant[0]), 64'(1));
        cyc_commit();
        clear_reqs();
        cyc_eval();
        chk("R2 read data from running target", 64'(req_rdata[0 +: DW]), 64'(seed_word(7, 3)));
        cyc_commit();
        // R7: direction change toward a stopped target does not stall
        set_req(0, 1, 6, 1, 2, 32'h1234_5678);
        cyc_eval();
        chk("R7 no stall on stopped target", 64'(req_grant[0]), 64'(1));
        cyc_commit();
        clear_reqs();

        // random traffic
        for (int c = 0; c < 4000; c++) begin
            if (c % 32 == 0) core_running = N'($urandom);
            cyc_eval();
            cyc_commit();
            for (int s = 0; s < N; s++) begin
                if (!req_valid[s] || e_grant[s] || req_error[s] || ($urandom % 10 == 0))
                    set_req(s, ($urandom % 3) != 0, int'($urandom % N), 1'($urandom),
                            int'($urandom % 16), $urandom);
            end
        end
        done = 1;
        finish_run();
    end
endmodule